// File: doc/BRIEF.md
# Programmable raster timing generator

This block produces the horizontal and vertical timing of a non-interlaced video raster. Software programs eight timing values over a small write-only register bus: the total, displayed and sync-window bounds for each axis. The block then drives horizontal and vertical sync, a display-enable strobe, a composite sync meant for the colour channels, and the live pixel and line counts. A pixel-fetch stage downstream uses these counts to find the pixel to show.

A two-state machine controls the raster. `ST_IDLE` holds both counters at zero and keeps every output at its inactive level. `ST_ACTIVE` advances the pixel counter once per clock, and the line counter on each pixel wrap. The transition START (`ST_IDLE` to `ST_ACTIVE`) happens when the run bit and the refresh bit of the control register are both set. The transition HALT (`ST_ACTIVE` to `ST_IDLE`) happens as soon as either bit is cleared.

Timing values pass through a shadow copy. While the block is idle the shadow follows the written values. While it runs, the shadow takes new values only at the end of a frame. Sync polarity, sync suppression and display blanking are not shadowed and act at once.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the control register is 0, both counters read 0, display-enable, hsync, vsync and composite sync are low, and the timing values hold a 1280x1024 mode. That mode has horizontal total 1688, sync from pixel 1328 to 1440, vertical total 1066 and sync from line 1025 to 1028.
- R2: While running, the pixel count steps by one per clock and wraps to 0 after total-1. The line count advances only on that wrap and wraps to 0 after vertical total-1.
- R3: Display-enable is high exactly when running, the pixel count is below the displayed width, the line count is below the displayed height, and blanking is off.
- R4: The raw horizontal sync is active when the pixel count is at or above sync start and below sync end.
- R5: The raw vertical sync is active when the line count is at or above sync start and below sync end.
- R6: In the sync register (address 9), bit 3 inverts hsync and bit 4 inverts vsync. Each output equals its raw sync XOR its invert bit.
- R7: In the sync register, bit 5 suppresses hsync, bit 6 suppresses vsync and bit 1 suppresses both. A suppressed output sits at its inactive level, which equals its invert bit.
- R8: Sync register bit 0 drives the composite sync output, which is the OR of the raw syncs. It reads 0 when bit 0 is clear or bit 1 is set.
- R9: Bit 1 of the display register (address 10) forces display-enable low while the counters and syncs keep running.
- R10: The raster runs only while control register (address 0) bits 0 and 1 are both set. Otherwise the counters are held at 0 and display-enable and the raw syncs are inactive. A restart begins at pixel 0, line 0.
- R11: A timing value written while running takes effect only after the clock in which the pixel count is horizontal total-1 and the line count is vertical total-1.
- R12: Timing values are written at word addresses 1 to 8. These hold, in order, horizontal total, displayed width, hsync start, hsync end, vertical total, displayed height, vsync start and vsync end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | CNT_W | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity and suppression |
| vsync_o | output | 1 | Vertical sync after polarity and suppression |
| rgb_sync_o | output | 1 | Composite sync for the colour channels |
| de_o | output | 1 | Display-enable |
| pix_o | output | CNT_W | Current pixel count |
| line_o | output | CNT_W | Current line count |

## Verification
A bad counter or shadow value shows at the ports in the next clock, because the pixel and line counts are outputs and the bench predicts them every cycle. A shadow that loads early or late changes the wrap point of the pixel count within the same frame, and display-enable and sync then sit at the wrong positions. Wrong state decoding shows within one clock of a control write, as non-zero counts while stopped or stuck counts while running.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } rtg_state_e;

    // register word addresses
    localparam int RA_CTRL = 0;
    localparam int RA_SYNC = 9;
    localparam int RA_DISP = 10;

    // timing value slots; address of slot i is i+1
    localparam int TI_HTOT = 0;
    localparam int TI_HACT = 1;
    localparam int TI_HSB  = 2;
    localparam int TI_HSE  = 3;
    localparam int TI_VTOT = 4;
    localparam int TI_VACT = 5;
    localparam int TI_VSB  = 6;
    localparam int TI_VSE  = 7;
    localparam int TI_NUM  = 8;

    // bits in the control register
    localparam int CB_RUN     = 0;
    localparam int CB_REFRESH = 1;

    // bits as written in the sync register
    localparam int SB_RGB  = 0;
    localparam int SB_ALL  = 1;
    localparam int SB_HINV = 3;
    localparam int SB_VINV = 4;
    localparam int SB_HOFF = 5;
    localparam int SB_VOFF = 6;

    // packed sync configuration handed to the output stage
    localparam int SC_RGB  = 0;
    localparam int SC_ALL  = 1;
    localparam int SC_HINV = 2;
    localparam int SC_VINV = 3;
    localparam int SC_HOFF = 4;
    localparam int SC_VOFF = 5;
    localparam int SC_W    = 6;

    localparam int DB_BLANK = 1;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int ADDR_W   = 4,
    parameter int DEF_HTOT = 1688,
    parameter int DEF_HACT = 1280,
    parameter int DEF_HSB  = 1328,
    parameter int DEF_HSE  = 1440,
    parameter int DEF_VTOT = 1066,
    parameter int DEF_VACT = 1024,
    parameter int DEF_VSB  = 1025,
    parameter int DEF_VSE  = 1028
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic                           load_shadow,
    output logic                           go_o,
    output logic [SC_W-1:0]                sync_cfg_o,
    output logic                           blank_o,
    output logic [TI_NUM-1:0][CNT_W-1:0]   tim_o
);

    localparam logic [TI_NUM-1:0][CNT_W-1:0] DEF_TIM = {
        CNT_W'(DEF_VSE), CNT_W'(DEF_VSB), CNT_W'(DEF_VACT), CNT_W'(DEF_VTOT),
        CNT_W'(DEF_HSE), CNT_W'(DEF_HSB), CNT_W'(DEF_HACT), CNT_W'(DEF_HTOT)
    };

    logic [TI_NUM-1:0][CNT_W-1:0] live_q;
    logic [TI_NUM-1:0][CNT_W-1:0] shad_q;
    logic [1:0]                   ctrl_q;

    generate
        for (genvar gi = 0; gi < TI_NUM; gi++) begin : g_tim
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    live_q[gi] <= DEF_TIM[gi];
                    shad_q[gi] <= DEF_TIM[gi];
                end else begin
                    if (wr_en && wr_addr == ADDR_W'(gi + 1)) begin
                        live_q[gi] <= wr_data;
                    end
                    if (load_shadow) begin
                        shad_q[gi] <= live_q[gi];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            sync_cfg_o <= '0;
            blank_o    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(RA_CTRL)) begin
                ctrl_q <= {wr_data[CB_REFRESH], wr_data[CB_RUN]};
            end
            if (wr_addr == ADDR_W'(RA_SYNC)) begin
                sync_cfg_o <= {wr_data[SB_VOFF], wr_data[SB_HOFF], wr_data[SB_VINV],
                               wr_data[SB_HINV], wr_data[SB_ALL], wr_data[SB_RGB]};
            end
            if (wr_addr == ADDR_W'(RA_DISP)) begin
                blank_o <= wr_data[DB_BLANK];
            end
        end
    end

    assign go_o  = &ctrl_q;
    assign tim_o = shad_q;

    // shadow copy moves only when the sequencer asks for it
    p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_shadow |=> $stable(tim_o));

endmodule

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] tot,
    input  logic [CNT_W-1:0] act,
    input  logic [CNT_W-1:0] sb,
    input  logic [CNT_W-1:0] se,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o,
    output logic             vis_o,
    output logic             syn_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (adv) begin
            cnt_o <= last_o ? '0 : cnt_o + CNT_W'(1);
        end
    end

    always_comb begin
        last_o = (cnt_o == tot - CNT_W'(1));
        vis_o  = (cnt_o < act);
        syn_o  = (cnt_o >= sb) && (cnt_o < se);
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && last_o) |=> (cnt_o == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && !last_o) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(cnt_o));

endmodule

// File: rtl/rtg_sync_out.sv
module rtg_sync_out
    import rtg_pkg::*;
(
    input  logic            h_raw,
    input  logic            v_raw,
    input  logic [SC_W-1:0] cfg,
    output logic            hs_o,
    output logic            vs_o,
    output logic            rgb_o
);

    logic h_kill;
    logic v_kill;

    always_comb begin
        h_kill = cfg[SC_HOFF] | cfg[SC_ALL];
        v_kill = cfg[SC_VOFF] | cfg[SC_ALL];
        hs_o   = h_kill ? cfg[SC_HINV] : (h_raw ^ cfg[SC_HINV]);
        vs_o   = v_kill ? cfg[SC_VINV] : (v_raw ^ cfg[SC_VINV]);
        rgb_o  = cfg[SC_RGB] & ~cfg[SC_ALL] & (h_raw | v_raw);
    end

    always_comb begin
        if (cfg[SC_ALL]) begin
            p_alloff_h_r7: assert (hs_o == cfg[SC_HINV]);
            p_alloff_v_r7: assert (vs_o == cfg[SC_VINV]);
            p_alloff_rgb_r8: assert (!rgb_o);
        end
        if (!cfg[SC_HOFF] && !cfg[SC_ALL] && !h_raw) begin
            p_h_idle_level_r6: assert (hs_o == cfg[SC_HINV]);
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 4,
    parameter int H_ACT  = 1280,
    parameter int H_FP   = 48,
    parameter int H_SW   = 112,
    parameter int H_BP   = 248,
    parameter int V_ACT  = 1024,
    parameter int V_FP   = 1,
    parameter int V_SW   = 3,
    parameter int V_BP   = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              rgb_sync_o,
    output logic              de_o,
    output logic [CNT_W-1:0]  pix_o,
    output logic [CNT_W-1:0]  line_o
);

    localparam int H_SB  = H_ACT + H_FP;
    localparam int H_SE  = H_SB + H_SW;
    localparam int H_TOT = H_SE + H_BP;
    localparam int V_SB  = V_ACT + V_FP;
    localparam int V_SE  = V_SB + V_SW;
    localparam int V_TOT = V_SE + V_BP;

    rtg_state_e state_q, state_d;

    logic                         go;
    logic                         blank;
    logic [SC_W-1:0]              sync_cfg;
    logic [TI_NUM-1:0][CNT_W-1:0] tim;
    logic                         running;
    logic                         cnt_clr;
    logic                         h_adv, v_adv;
    logic                         h_last, v_last;
    logic                         h_vis, v_vis;
    logic                         h_syn, v_syn;
    logic                         frame_end;
    logic                         load_shadow;
    logic                         h_raw, v_raw;

    rtg_regs #(
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .DEF_HTOT(H_TOT),
        .DEF_HACT(H_ACT),
        .DEF_HSB (H_SB),
        .DEF_HSE (H_SE),
        .DEF_VTOT(V_TOT),
        .DEF_VACT(V_ACT),
        .DEF_VSB (V_SB),
        .DEF_VSE (V_SE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .load_shadow(load_shadow),
        .go_o       (go),
        .sync_cfg_o (sync_cfg),
        .blank_o    (blank),
        .tim_o      (tim)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START (idle -> active), HALT (active -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (!go) state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        running     = (state_q == ST_ACTIVE);
        cnt_clr     = !running;
        h_adv       = running;
        v_adv       = running && h_last;
        frame_end   = running && h_last && v_last;
        load_shadow = !running || frame_end;
        h_raw       = running && h_syn;
        v_raw       = running && v_syn;
        de_o        = running && h_vis && v_vis && !blank;
    end

    rtg_axis_counter #(.CNT_W(CNT_W)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (h_adv),
        .tot   (tim[TI_HTOT]),
        .act   (tim[TI_HACT]),
        .sb    (tim[TI_HSB]),
        .se    (tim[TI_HSE]),
        .cnt_o (pix_o),
        .last_o(h_last),
        .vis_o (h_vis),
        .syn_o (h_syn)
    );

    rtg_axis_counter #(.CNT_W(CNT_W)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .adv   (v_adv),
        .tot   (tim[TI_VTOT]),
        .act   (tim[TI_VACT]),
        .sb    (tim[TI_VSB]),
        .se    (tim[TI_VSE]),
        .cnt_o (line_o),
        .last_o(v_last),
        .vis_o (v_vis),
        .syn_o (v_syn)
    );

    rtg_sync_out u_sync (
        .h_raw(h_raw),
        .v_raw(v_raw),
        .cfg  (sync_cfg),
        .hs_o (hsync_o),
        .vs_o (vsync_o),
        .rgb_o(rgb_sync_o)
    );

    p_de_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (pix_o < tim[TI_HACT] && line_o < tim[TI_VACT]));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (pix_o == '0 && line_o == '0));

    p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && go && !h_last) |=> $stable(line_o));

    p_start_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (pix_o == '0 && line_o == '0));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic        hsync_o, vsync_o, rgb_sync_o, de_o;
    logic [11:0] pix_o, line_o;

    always #10 clk = ~clk;

    raster_timing_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .rgb_sync_o(rgb_sync_o),
        .de_o      (de_o),
        .pix_o     (pix_o),
        .line_o    (line_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit mon_en = 1'b0;
    int max_pix = 0;
    int first_hs = -1;
    logic hs_prev = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected machine state, derived from the requirements
    logic [11:0] m_live [8];
    logic [11:0] m_sh   [8];
    logic [1:0]  m_ctrl;
    logic [5:0]  m_sync;   // {voff,hoff,vinv,hinv,all,rgb}
    logic        m_blank;
    logic        m_act;
    logic [11:0] m_pix, m_line;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_live[0] <= 12'd1688; m_live[1] <= 12'd1280;
            m_live[2] <= 12'd1328; m_live[3] <= 12'd1440;
            m_live[4] <= 12'd1066; m_live[5] <= 12'd1024;
            m_live[6] <= 12'd1025; m_live[7] <= 12'd1028;
            m_sh[0] <= 12'd1688; m_sh[1] <= 12'd1280;
            m_sh[2] <= 12'd1328; m_sh[3] <= 12'd1440;
            m_sh[4] <= 12'd1066; m_sh[5] <= 12'd1024;
            m_sh[6] <= 12'd1025; m_sh[7] <= 12'd1028;
            m_ctrl <= 2'b00; m_sync <= '0; m_blank <= 1'b0;
            m_act <= 1'b0; m_pix <= '0; m_line <= '0;
        end else begin
            if (!m_act) begin
                m_pix <= '0;
                m_line <= '0;
                for (int i = 0; i < 8; i++) m_sh[i] <= m_live[i];
            end else if (m_pix == m_sh[0] - 12'd1) begin
                m_pix <= '0;
                if (m_line == m_sh[4] - 12'd1) begin
                    m_line <= '0;
                    for (int i = 0; i < 8; i++) m_sh[i] <= m_live[i];
                end else begin
                    m_line <= m_line + 12'd1;
                end
            end else begin
                m_pix <= m_pix + 12'd1;
            end
            m_act <= (m_ctrl == 2'b11);
            if (reg_wr) begin
                if (reg_addr == 4'd0) m_ctrl <= reg_wdata[1:0];
                if (reg_addr >= 4'd1 && reg_addr <= 4'd8) m_live[reg_addr - 4'd1] <= reg_wdata;
                if (reg_addr == 4'd9)
                    m_sync <= {reg_wdata[6:3], reg_wdata[1:0]};
                if (reg_addr == 4'd10) m_blank <= reg_wdata[1];
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            logic hr, vr, e_de, e_hs, e_vs, e_rgb;
            hr = m_act && m_pix >= m_sh[2] && m_pix < m_sh[3];
            vr = m_act && m_line >= m_sh[6] && m_line < m_sh[7];
            e_de = m_act && m_pix < m_sh[1] && m_line < m_sh[5] && !m_blank;
            e_hs = (m_sync[4] | m_sync[1]) ? m_sync[2] : (hr ^ m_sync[2]);
            e_vs = (m_sync[5] | m_sync[1]) ? m_sync[3] : (vr ^ m_sync[3]);
            e_rgb = m_sync[0] && !m_sync[1] && (hr || vr);
            chk(m_act ? "R2 pixel" : "R10 pixel", int'(pix_o), int'(m_pix));
            chk(m_act ? "R2 line" : "R10 line", int'(line_o), int'(m_line));
            chk(m_blank ? "R9 de" : "R3 de", int'(de_o), int'(e_de));
            chk("R4/R6/R7 hsync", int'(hsync_o), int'(e_hs));
            chk("R5/R6/R7 vsync", int'(vsync_o), int'(e_vs));
            chk("R8 rgb sync", int'(rgb_sync_o), int'(e_rgb));
            if (int'(pix_o) > max_pix) max_pix = int'(pix_o);
            if (hsync_o && !hs_prev && first_hs < 0) first_hs = int'(pix_o);
            hs_prev = hsync_o;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = 4'(a);
        reg_wdata = 12'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_at(input int p, input int l);
        while (!(int'(pix_o) == p && int'(line_o) == l)) @(negedge clk);
    endtask

    task automatic setup(input int ht, input int ha, input int hb, input int he,
                         input int vt, input int va, input int vb, input int ve);
        wr(0, 0);
        wr(1, ht); wr(2, ha); wr(3, hb); wr(4, he);
        wr(5, vt); wr(6, va); wr(7, vb); wr(8, ve);
        wr(0, 3);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        run(3);
        // R1: reset state
        chk("R1 pixel", int'(pix_o), 0);
        chk("R1 line", int'(line_o), 0);
        chk("R1 de", int'(de_o), 0);
        chk("R1 hsync", int'(hsync_o), 0);
        chk("R1 vsync", int'(vsync_o), 0);
        chk("R1 rgb", int'(rgb_sync_o), 0);
        rst_n = 1'b1;
        run(2);
        mon_en = 1'b1;

        // R1: default mode, two lines
        max_pix = 0;
        first_hs = -1;
        wr(0, 3);
        run(3500);
        chk("R1 default wrap", max_pix, 1687);
        chk("R1 default hsync start", first_hs, 1328);

        // R10: either bit alone stops the raster
        wr(0, 1);
        run(3);
        chk("R10 run only", int'(pix_o) + int'(line_o) + int'(de_o), 0);
        wr(0, 2);
        run(3);
        chk("R10 refresh only", int'(pix_o) + int'(line_o) + int'(de_o), 0);

        // sweep of small geometries
        for (int ht = 6; ht <= 9; ht++) begin
            for (int vt = 4; vt <= 6; vt++) begin
                setup(ht, ht - 2, ht - 3, ht - 1, vt, vt - 1, vt - 1, vt);
                run(3 * ht * vt + 5);
            end
        end

        // sync control sweep over all values of bits 0..6
        setup(8, 5, 5, 7, 5, 3, 3, 4);
        for (int c = 0; c < 128; c++) begin
            wr(9, c);
            run(13);
        end
        wr(9, 0);

        // R9: blanking leaves timing running
        begin
            int de_hi = 0;
            int hs_hi = 0;
            wr(10, 2);
            repeat (60) begin
                @(negedge clk);
                if (de_o) de_hi++;
                if (hsync_o) hs_hi++;
            end
            chk("R9 de held low", de_hi, 0);
            chk("R9 sync still toggles", int'(hs_hi > 0), 1);
            wr(10, 0);
        end

        // R11: mid-frame write waits for the frame boundary
        wait_at(0, 2);
        wr(1, 12);
        max_pix = 0;
        while (!(int'(pix_o) == 0 && int'(line_o) == 0)) @(negedge clk);
        chk("R11 old total kept", max_pix, 7);
        max_pix = 0;
        run(60);
        chk("R11 new total used", max_pix, 11);

        // R12: each timing address reaches its own value
        setup(10, 4, 5, 7, 4, 2, 2, 3);
        wait_at(3, 0);
        chk("R12 de inside width", int'(de_o), 1);
        chk("R12 hsync before start", int'(hsync_o), 0);
        wait_at(4, 0);
        chk("R12 de at width", int'(de_o), 0);
        wait_at(5, 0);
        chk("R12 hsync at start", int'(hsync_o), 1);
        wait_at(7, 0);
        chk("R12 hsync at end", int'(hsync_o), 0);
        wait_at(0, 2);
        chk("R12 vsync at start", int'(vsync_o), 1);
        chk("R12 de below height", int'(de_o), 0);
        wait_at(0, 3);
        chk("R12 vsync at end", int'(vsync_o), 0);
        wait_at(9, 3);
        run(1);
        chk("R12 vertical wrap", int'(line_o), 0);

        // R10: halt mid-line, restart from origin
        wait_at(3, 1);
        wr(0, 0);
        run(4);
        chk("R10 halted pixel", int'(pix_o), 0);
        chk("R10 halted line", int'(line_o), 0);
        wr(0, 3);
        chk("R10 restart origin", int'(pix_o) + int'(line_o), 0);
        run(50);

        mon_en = 1'b0;
        finish_up();
    end

endmodule